// File: doc/BRIEF.md
# Register Transfer Micro-Operation Datapath

This block is a three-register datapath that carries out one register transfer micro-operation per clock cycle. The registers are called R0, R1 and R2, and each is WIDTH bits wide. Each operation has its own control strobe:

- **Arithmetic:** adds R2 to R1, or subtracts R2 from R1 by two's-complement negation. It records a carry flag and an overflow flag.
- **Logic:** writes NOT, AND, OR or XOR of R1 and R2 into R0.
- **Shift:** moves R1 one place left or right in place, filling the vacated bit with zero.
- **Transfer:** copies R1 or R2 into R0 through a 2:1 multiplexer. The R1 path takes priority.

A plain load port seeds any register with a value from outside the block.

The block is intended to sit under a sequencer that raises at most one strobe group per cycle. When no strobe is raised, every register and both flags hold their values. The register contents and the two flags are visible on the outputs at all times. There is no streaming data path, so every pin is a plain level-sampled control or status signal and there is no back-pressure.

Top module: `rt_datapath`

## Requirements
- R1: A synchronous `rst` clears R0, R1, R2, `flag_c` and `flag_v` to zero at the next rising clock edge.
- R2: With `ld_en` high, `ld_data` is written to the register chosen by `ld_sel`: 0 selects R0, 1 selects R1 and 2 selects R2. With `ld_sel` equal to 3, no register changes.
- R3: With `arith_go` high and `sub_mode` low, R1 becomes R1 + R2 modulo 2^WIDTH. `flag_c` takes the carry out of the top bit. `flag_v` takes the XOR of the carries out of the top two bit positions, which equals signed overflow.
- R4: With `arith_go` high and `sub_mode` high, R1 becomes R1 + NOT R2 + 1. `flag_c` is 1 exactly when no borrow occurs (R1 >= R2 unsigned). Negating the most negative value (0 minus 100..0) sets `flag_v`.
- R5: With `logic_go` high, R0 receives a bitwise function of R1 and R2 chosen by `logic_sel`: 0 gives NOT R1, 1 gives AND, 2 gives OR and 3 gives XOR.
- R6: With `shift_go` high, R1 shifts one place in place. `shift_left` = 0 moves bit i+1 to bit i and puts 0 in the MSB. `shift_left` = 1 moves bit i-1 to bit i and puts 0 in the LSB.
- R7: With `xfer_a` high, R0 receives R1. With `xfer_a` low and `xfer_b` high, R0 receives R2. The R0 load enable is `xfer_a` OR `xfer_b`, and the mux select is `xfer_a`.
- R8: Only arithmetic operations change `flag_c` and `flag_v`. Load, logic, shift and transfer leave both flags unchanged.
- R9: In a cycle with no strobe, all registers and flags keep their values.
- R10: At most one of the groups load, arithmetic, logic, shift and transfer is active in a cycle. `xfer_a` and `xfer_b` together count as one group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | External load strobe |
| ld_sel | input | 2 | Load destination: 0 R0, 1 R1, 2 R2, 3 none |
| ld_data | input | WIDTH | Value to load |
| arith_go | input | 1 | Arithmetic strobe |
| sub_mode | input | 1 | 0 add, 1 subtract |
| logic_go | input | 1 | Logic strobe |
| logic_sel | input | 2 | 0 NOT, 1 AND, 2 OR, 3 XOR |
| shift_go | input | 1 | Shift strobe |
| shift_left | input | 1 | 0 right, 1 left |
| xfer_a | input | 1 | Priority transfer R1 to R0 |
| xfer_b | input | 1 | Secondary transfer R2 to R0 |
| r0 | output | WIDTH | Register R0 |
| r1 | output | WIDTH | Register R1 |
| r2 | output | WIDTH | Register R2 |
| flag_c | output | 1 | Carry status |
| flag_v | output | 1 | Overflow status |

## Verification
The assertions check the following on every cycle:
- the overflow flag agrees with a sign-based overflow rule;
- the add result lands in R1;
- a right shift clears the MSB;
- the secondary transfer path loads R2;
- non-arithmetic strobes and idle cycles leave the flags or all state unchanged;
- only one strobe group is active at a time.

Only the bench scenarios show the exact carry values at the corner operands: wraparound from all ones, adding two most negative values, and negating the most negative value. The scenarios also cover each of the four logic functions, the choice of the R1 path when both transfer strobes are high, and the ignored load code.

// File: rtl/rtdp_pkg.sv
package rtdp_pkg;
  typedef enum logic [1:0] {
    LG_NOT = 2'd0,
    LG_AND = 2'd1,
    LG_OR  = 2'd2,
    LG_XOR = 2'd3
  } logic_fn_e;

  typedef enum logic [1:0] {
    DST_R0   = 2'd0,
    DST_R1   = 2'd1,
    DST_R2   = 2'd2,
    DST_NONE = 2'd3
  } dst_e;

  typedef struct packed {
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/rtdp_addsub.sv
module rtdp_addsub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);
  localparam int LOW = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;
  logic [LOW:0]     low_part;
  logic             c_top_in;

  always_comb begin
    b_eff    = sub ? ~b : b;
    full     = {1'b0, a} + {1'b0, b_eff} + (WIDTH+1)'(sub);
    low_part = {1'b0, a[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]} + (LOW+1)'(sub);
    c_top_in = low_part[LOW];
    sum      = full[WIDTH-1:0];
    carry    = full[WIDTH];
    ovf      = full[WIDTH] ^ c_top_in;
  end

  // R3/R4: carry-XOR overflow must match the sign-based rule
  always_comb begin
    if (!$isunknown({a, b, sub})) begin
      assert_vsign_R3: assert (ovf == ((a[WIDTH-1] == b_eff[WIDTH-1]) &&
                                       (sum[WIDTH-1] != a[WIDTH-1])))
        else $error("overflow flag disagrees with sign rule");
    end
  end
endmodule

// File: rtl/rtdp_logic_unit.sv
module rtdp_logic_unit
  import rtdp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_fn_e        fn,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (fn)
      LG_NOT:  y = ~a;
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/rtdp_shifter.sv
module rtdp_shifter #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic             left,
  output logic [WIDTH-1:0] y
);
  logic [WIDTH-1:0] rgt;
  logic [WIDTH-1:0] lft;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      assign rgt[i] = 1'b0;
    end else begin : g_rmid
      assign rgt[i] = a[i+1];
    end
    if (i == 0) begin : g_bot
      assign lft[i] = 1'b0;
    end else begin : g_lmid
      assign lft[i] = a[i-1];
    end
  end

  assign y = left ? lft : rgt;
endmodule

// File: rtl/rtdp_xfer_ctrl.sv
module rtdp_xfer_ctrl #(
  parameter int WIDTH = 4
) (
  input  logic             k_pri,
  input  logic             k_alt,
  input  logic [WIDTH-1:0] src_pri,
  input  logic [WIDTH-1:0] src_alt,
  output logic             load_en,
  output logic [WIDTH-1:0] mux_out
);
  logic sel;

  always_comb begin
    load_en = k_pri | k_alt;
    sel     = k_pri;
    mux_out = sel ? src_pri : src_alt;
  end
endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rtdp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [1:0]       ld_sel,
  input  logic [WIDTH-1:0] ld_data,
  input  logic             arith_go,
  input  logic             sub_mode,
  input  logic             logic_go,
  input  logic [1:0]       logic_sel,
  input  logic             shift_go,
  input  logic             shift_left,
  input  logic             xfer_a,
  input  logic             xfer_b,
  output logic [WIDTH-1:0] r0,
  output logic [WIDTH-1:0] r1,
  output logic [WIDTH-1:0] r2,
  output logic             flag_c,
  output logic             flag_v
);
  logic [WIDTH-1:0] r0_q, r1_q, r2_q;
  logic [WIDTH-1:0] r0_d, r1_d, r2_d;
  flags_t           flg_q, flg_d;

  logic [WIDTH-1:0] as_sum;
  logic             as_c, as_v;
  logic [WIDTH-1:0] lg_y;
  logic [WIDTH-1:0] sh_y;
  logic             xf_ld;
  logic [WIDTH-1:0] xf_y;
  dst_e             ld_dst;

  assign ld_dst = dst_e'(ld_sel);

  rtdp_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(r1_q), .b(r2_q), .sub(sub_mode),
    .sum(as_sum), .carry(as_c), .ovf(as_v)
  );

  rtdp_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a(r1_q), .b(r2_q), .fn(logic_fn_e'(logic_sel)), .y(lg_y)
  );

  rtdp_shifter #(.WIDTH(WIDTH)) u_shift (
    .a(r1_q), .left(shift_left), .y(sh_y)
  );

  rtdp_xfer_ctrl #(.WIDTH(WIDTH)) u_xfer (
    .k_pri(xfer_a), .k_alt(xfer_b), .src_pri(r1_q), .src_alt(r2_q),
    .load_en(xf_ld), .mux_out(xf_y)
  );

  // One operation per cycle; a fixed order resolves illegal overlaps.
  always_comb begin
    r0_d  = r0_q;
    r1_d  = r1_q;
    r2_d  = r2_q;
    flg_d = flg_q;
    if (ld_en) begin
      unique case (ld_dst)
        DST_R0:  r0_d = ld_data;
        DST_R1:  r1_d = ld_data;
        DST_R2:  r2_d = ld_data;
        default: ;
      endcase
    end else if (arith_go) begin
      r1_d    = as_sum;
      flg_d.c = as_c;
      flg_d.v = as_v;
    end else if (logic_go) begin
      r0_d = lg_y;
    end else if (shift_go) begin
      r1_d = sh_y;
    end else if (xf_ld) begin
      r0_d = xf_y;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r0_q  <= '0;
      r1_q  <= '0;
      r2_q  <= '0;
      flg_q <= '0;
    end else begin
      r0_q  <= r0_d;
      r1_q  <= r1_d;
      r2_q  <= r2_d;
      flg_q <= flg_d;
    end
  end

  assign r0     = r0_q;
  assign r1     = r1_q;
  assign r2     = r2_q;
  assign flag_c = flg_q.c;
  assign flag_v = flg_q.v;

  logic any_go;
  assign any_go = ld_en | arith_go | logic_go | shift_go | xfer_a | xfer_b;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (r0 == '0 && r1 == '0 && r2 == '0 && !flag_c && !flag_v))
    else $error("reset did not clear state");

  assert_add_result_R3: assert property (@(posedge clk) disable iff (rst)
    (arith_go && !sub_mode && !ld_en) |=>
      r1 == WIDTH'($past(r1) + $past(r2)))
    else $error("add result wrong");

  assert_shr_msb_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (shift_go && !shift_left && !ld_en && !arith_go && !logic_go) |=> !r1[WIDTH-1])
    else $error("right shift left MSB set");

  assert_xfer_alt_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_b && !xfer_a && !ld_en && !arith_go && !logic_go && !shift_go) |=>
      r0 == $past(r2))
    else $error("secondary transfer did not load R2");

  assert_flags_keep_R8: assert property (@(posedge clk) disable iff (rst)
    !arith_go |=> ($stable(flag_c) && $stable(flag_v)))
    else $error("flags changed without arithmetic");

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !any_go |=> ($stable(r0) && $stable(r1) && $stable(r2)))
    else $error("state changed in idle cycle");

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({ld_en, arith_go, logic_go, shift_go, xfer_a | xfer_b}) <= 1)
    else $error("more than one strobe group active");
endmodule

// File: tb/test_rt_datapath.sv
module test_rt_datapath;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int SMAX = (1 << (W-1)) - 1;
  localparam int SMIN = -(1 << (W-1));

  logic         clk = 1'b0;
  logic         rst;
  logic         ld_en, arith_go, sub_mode, logic_go, shift_go, shift_left, xfer_a, xfer_b;
  logic [1:0]   ld_sel, logic_sel;
  logic [W-1:0] ld_data;
  logic [W-1:0] r0, r1, r2;
  logic         flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  int m_r0, m_r1, m_r2, m_c, m_v;

  always #2 clk = ~clk;

  rt_datapath #(.WIDTH(W)) i_rt_datapath (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .arith_go(arith_go), .sub_mode(sub_mode), .logic_go(logic_go),
    .logic_sel(logic_sel), .shift_go(shift_go), .shift_left(shift_left),
    .xfer_a(xfer_a), .xfer_b(xfer_b), .r0(r0), .r1(r1), .r2(r2),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  function automatic int to_s(int x);
    return (x > SMAX) ? x - (1 << W) : x;
  endfunction

  task automatic clear_strobes();
    ld_en = 0; arith_go = 0; logic_go = 0; shift_go = 0;
    xfer_a = 0; xfer_b = 0;
  endtask

  task automatic compare(string tag);
    checks++;
    if (int'(r0) != m_r0 || int'(r1) != m_r1 || int'(r2) != m_r2 ||
        int'(flag_c) != m_c || int'(flag_v) != m_v) begin
      fails++;
      $display("FAIL %s: got r0=%0d r1=%0d r2=%0d c=%0d v=%0d exp r0=%0d r1=%0d r2=%0d c=%0d v=%0d",
               tag, r0, r1, r2, flag_c, flag_v, m_r0, m_r1, m_r2, m_c, m_v);
    end
  endtask

  task automatic finish_step(string tag);
    @(negedge clk);
    clear_strobes();
    compare(tag);
  endtask

  task automatic do_load(int sel, int val, string tag);
    @(negedge clk);
    ld_en = 1; ld_sel = 2'(sel); ld_data = W'(val);
    if (sel == 0) m_r0 = val & MASK;
    else if (sel == 1) m_r1 = val & MASK;
    else if (sel == 2) m_r2 = val & MASK;
    finish_step(tag);
  endtask

  task automatic do_arith(bit sub, string tag);
    int beff, full, res;
    beff = sub ? (~m_r2 & MASK) : m_r2;
    full = m_r1 + beff + int'(sub);
    res  = sub ? to_s(m_r1) - to_s(m_r2) : to_s(m_r1) + to_s(m_r2);
    m_c  = (full >> W) & 1;
    m_v  = (res > SMAX || res < SMIN) ? 1 : 0;
    m_r1 = full & MASK;
    @(negedge clk);
    arith_go = 1; sub_mode = sub;
    finish_step(tag);
  endtask

  task automatic do_logic(int fn, string tag);
    case (fn)
      0: m_r0 = ~m_r1 & MASK;
      1: m_r0 = m_r1 & m_r2;
      2: m_r0 = m_r1 | m_r2;
      default: m_r0 = m_r1 ^ m_r2;
    endcase
    @(negedge clk);
    logic_go = 1; logic_sel = 2'(fn);
    finish_step(tag);
  endtask

  task automatic do_shift(bit left, string tag);
    m_r1 = left ? ((m_r1 << 1) & MASK) : (m_r1 >> 1);
    @(negedge clk);
    shift_go = 1; shift_left = left;
    finish_step(tag);
  endtask

  task automatic do_xfer(bit a, bit b, string tag);
    if (a) m_r0 = m_r1;
    else if (b) m_r0 = m_r2;
    @(negedge clk);
    xfer_a = a; xfer_b = b;
    finish_step(tag);
  endtask

  task automatic test_reset();
    rst = 1; clear_strobes(); sub_mode = 0; shift_left = 0;
    ld_sel = 0; logic_sel = 0; ld_data = '0;
    m_r0 = 0; m_r1 = 0; m_r2 = 0; m_c = 0; m_v = 0;
    repeat (2) @(negedge clk);
    compare("R1 reset clear");
    rst = 0;
  endtask

  task automatic test_load();
    do_load(0, 9, "R2 load R0");
    do_load(1, 3, "R2 load R1");
    do_load(2, 5, "R2 load R2");
    do_load(3, 15, "R2 sel 3 no write");
  endtask

  task automatic test_add();
    do_arith(0, "R3 add 3+5 signed overflow");
    do_load(1, 15, "R2 seed");
    do_load(2, 1, "R2 seed");
    do_arith(0, "R3 add -1+1 carry");
    do_load(1, 8, "R2 seed");
    do_load(2, 8, "R2 seed");
    do_arith(0, "R3 add min+min C and V");
    do_load(1, 2, "R2 seed");
    do_load(2, 3, "R2 seed");
    do_arith(0, "R3 add 2+3 no flags");
  endtask

  task automatic test_sub();
    do_load(1, 5, "R2 seed");
    do_load(2, 3, "R2 seed");
    do_arith(1, "R4 sub 5-3 no borrow");
    do_load(1, 3, "R2 seed");
    do_load(2, 5, "R2 seed");
    do_arith(1, "R4 sub 3-5 borrow");
    do_load(1, 0, "R2 seed");
    do_load(2, 8, "R2 seed");
    do_arith(1, "R4 negate most negative");
  endtask

  task automatic test_logic();
    do_load(1, 12, "R2 seed");
    do_load(2, 10, "R2 seed");
    do_logic(0, "R5 NOT");
    do_logic(1, "R5 AND");
    do_logic(2, "R5 OR");
    do_logic(3, "R5 XOR and R8 flags kept");
  endtask

  task automatic test_shift();
    do_load(1, 9, "R2 seed");
    do_shift(0, "R6 right zero MSB");
    do_shift(1, "R6 left zero LSB");
    do_load(1, 15, "R2 seed");
    do_shift(1, "R6 left drop MSB");
  endtask

  task automatic test_xfer();
    do_load(1, 6, "R2 seed");
    do_load(2, 11, "R2 seed");
    do_xfer(0, 1, "R7 alt path R2");
    do_xfer(1, 0, "R7 pri path R1");
    do_load(0, 0, "R2 seed");
    do_xfer(1, 1, "R7 both picks R1 R8 flags kept");
  endtask

  task automatic test_idle();
    @(negedge clk);
    compare("R9 idle hold");
    @(negedge clk);
    compare("R9 idle hold again");
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_load();
    test_add();
    test_sub();
    test_logic();
    test_shift();
    test_xfer();
    test_idle();
    // R10: every scenario above raises a single strobe group per cycle
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule